// File: doc/BRIEF.md
# Mask-Driven Vector Compress/Expand Unit

This block rearranges the elements of one vector under the control of a per-element mask. In the pack direction it gathers the elements whose mask bit is set and stacks them, lowest first, into the bottom of the result vector. It also reports how many elements were gathered, which is the population count of the mask. In the unpack direction it does the reverse: the lowest source elements are dealt out, in ascending order, to the positions whose mask bit is set. Every position the operation does not write keeps the value of a second input vector, the prior destination contents.

A request is launched with a single-cycle `start` while the unit is idle. The result and length registers update together and are flagged by a one-cycle `done` pulse. They then hold until the next accepted request. The parameter `SERIAL` picks the datapath. With `SERIAL=1` one element is visited per cycle through a small step engine. With `SERIAL=0` the whole permutation is computed combinationally from prefix counts of the mask and is registered in the accepting cycle.

The controller has three states. `ST_IDLE` waits for `start`. `ST_SCAN` walks the elements in the serial variant only. `ST_DONE` presents `done` for one cycle. There are four transitions. `ST_IDLE` goes to `ST_SCAN` on `start` when `SERIAL=1`, and to `ST_DONE` on `start` when `SERIAL=0`. `ST_SCAN` goes to `ST_DONE` after the last element is visited. `ST_DONE` always returns to `ST_IDLE`.

Top module: `vperm_unit`

## Requirements
- R1: With `dir`=0 (pack), result element j for j below the popcount equals the source element at the position of the (j+1)-th set mask bit, counted from bit 0, so the relative order of the selected elements is kept.
- R2: With `dir`=0, result elements at positions at or above the popcount equal the matching elements of `dst_flat`.
- R3: `packed_len` equals the number of set bits in the mask of the accepted request. It is 0 for an all-zero mask and `NUM_ELEM` for an all-ones mask.
- R4: With `dir`=1 (unpack), the k-th source element (k counted from 0) is placed at the position of the (k+1)-th set mask bit, counted from bit 0.
- R5: With `dir`=1, result positions whose mask bit is clear equal the matching elements of `dst_flat`. An all-zero mask returns `dst_flat` unchanged.
- R6: Mask bit i controls element i, and element i occupies bits [i*ELEM_W +: ELEM_W] of every vector port. Element 0 is in the least significant bits.
- R7: `done` is high for exactly one cycle. Counting the cycle in which `start` is accepted as cycle 0, `done` is high in cycle `NUM_ELEM`+1 when `SERIAL=1` and in cycle 1 when `SERIAL=0`. `result_flat` and `packed_len` hold their values until the next accepted request.
- R8: `start` is ignored while `busy` is high, including the cycle in which `done` is high. It launches no second run and does not alter the result in progress.
- R9: While `rst_n` is low, `busy`, `done`, `result_flat` and `packed_len` are all zero.
- R10: Both datapath variants give identical `result_flat` and `packed_len` for the same request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request; sampled only while idle |
| dir | input | 1 | 0 = pack (compress), 1 = unpack (expand) |
| mask | input | NUM_ELEM | Element select bits, bit i for element i |
| src_flat | input | NUM_ELEM*ELEM_W | Source vector |
| dst_flat | input | NUM_ELEM*ELEM_W | Prior destination contents used for unwritten positions |
| busy | output | 1 | High from the cycle after acceptance until `done` has been shown |
| done | output | 1 | One-cycle pulse marking a valid result |
| result_flat | output | NUM_ELEM*ELEM_W | Permuted vector |
| packed_len | output | $clog2(NUM_ELEM+1) | Population count of the accepted mask |

## Verification
The bench targets masks with a set bit at element 0 or only at the top element. A design that miscounts ranks by one would put the lone element in the wrong slot or read the wrong source. All-zero and all-ones masks catch a unit that clobbers the tail instead of keeping the destination, or that wraps the length counter to zero at full population. Alternating masks in both directions expose mixed-up gather and scatter indexing, which would give an interleaved rather than a packed result. A second `start` raised during the scan and in the `done` cycle would, in a unit with a loose idle check, restart the walk, corrupt the result or produce a stray extra `done`.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } vperm_state_e;

    typedef enum logic {
        DIR_PACK   = 1'b0,
        DIR_UNPACK = 1'b1
    } vperm_dir_e;

endpackage

// File: rtl/vperm_rank.sv
// Exclusive prefix count of the mask: rank[i] is the number of set bits
// below position i; total is the full population count.
module vperm_rank #(
    parameter int N  = 8,
    parameter int LW = $clog2(N + 1)
) (
    input  logic [N-1:0]  mask,
    output logic [LW-1:0] rank [N],
    output logic [LW-1:0] total
);

    always_comb begin
        logic [LW-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            rank[i] = acc;
            acc     = acc + LW'(mask[i]);
        end
        total = acc;
    end

endmodule

// File: rtl/vperm_parallel.sv
// Whole-vector combinational permutation built on the prefix ranks.
module vperm_parallel
    import vperm_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int LW = $clog2(N + 1),
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          dir,
    input  logic [N-1:0]  mask,
    input  logic [W-1:0]  src [N],
    input  logic [W-1:0]  dst [N],
    output logic [W-1:0]  res [N],
    output logic [LW-1:0] len
);

    logic [LW-1:0] rank [N];
    logic [LW-1:0] total;

    vperm_rank #(.N(N), .LW(LW)) u_rank (
        .mask  (mask),
        .rank  (rank),
        .total (total)
    );

    // Gather: destination slot j receives the selected element whose rank is j.
    logic [W-1:0] pack_res [N];
    always_comb begin
        for (int j = 0; j < N; j++) begin
            pack_res[j] = dst[j];
            for (int i = 0; i < N; i++) begin
                if (mask[i] && (rank[i] == LW'(j))) begin
                    pack_res[j] = src[i];
                end
            end
        end
    end

    // Scatter: a selected slot i reads the source element numbered by its rank.
    logic [W-1:0] unpack_res [N];
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (mask[i]) begin
                unpack_res[i] = src[rank[i][IW-1:0]];
            end else begin
                unpack_res[i] = dst[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            res[i] = (dir == DIR_UNPACK) ? unpack_res[i] : pack_res[i];
        end
        len = total;
    end

endmodule

// File: rtl/vperm_serial_step.sv
// One element visit of the serial engine: given the element index, the
// count of selected elements seen so far and the working vector, produce
// the updated working vector and count.
module vperm_serial_step
    import vperm_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int LW = $clog2(N + 1),
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          dir,
    input  logic          bit_set,
    input  logic [IW-1:0] idx,
    input  logic [LW-1:0] ptr,
    input  logic [W-1:0]  src      [N],
    input  logic [W-1:0]  work     [N],
    output logic [W-1:0]  work_nxt [N],
    output logic [LW-1:0] ptr_nxt
);

    logic [IW-1:0] slot;
    assign slot = ptr[IW-1:0];

    always_comb begin
        work_nxt = work;
        ptr_nxt  = ptr;
        if (bit_set) begin
            if (dir == DIR_UNPACK) begin
                work_nxt[idx] = src[slot];
            end else begin
                work_nxt[slot] = src[idx];
            end
            ptr_nxt = ptr + 1'b1;
        end
    end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
    import vperm_pkg::*;
#(
    parameter int ELEM_W   = 8,
    parameter int NUM_ELEM = 8,
    parameter int SERIAL   = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         dir,
    input  logic [NUM_ELEM-1:0]          mask,
    input  logic [NUM_ELEM*ELEM_W-1:0]   src_flat,
    input  logic [NUM_ELEM*ELEM_W-1:0]   dst_flat,
    output logic                         busy,
    output logic                         done,
    output logic [NUM_ELEM*ELEM_W-1:0]   result_flat,
    output logic [$clog2(NUM_ELEM+1)-1:0] packed_len
);

    localparam int N  = NUM_ELEM;
    localparam int W  = ELEM_W;
    localparam int LW = $clog2(N + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    vperm_state_e state, state_nxt;

    logic [W-1:0]  src_arr [N];
    logic [W-1:0]  dst_arr [N];
    logic [W-1:0]  res_q   [N];
    logic [LW-1:0] len_q;
    logic [N-1:0]  cap_mask;
    logic          scan_last;
    logic          accept;

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign src_arr[g]               = src_flat[g*W +: W];
        assign dst_arr[g]               = dst_flat[g*W +: W];
        assign result_flat[g*W +: W]    = res_q[g];
    end
    assign packed_len = len_q;

    assign accept = start && (state == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = (SERIAL != 0) ? ST_SCAN : ST_DONE;
                end
            end
            ST_SCAN: begin
                if (scan_last) begin
                    state_nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    if (SERIAL != 0) begin : g_serial
        logic [W-1:0]  cap_src   [N];
        logic [W-1:0]  work      [N];
        logic [W-1:0]  step_work [N];
        logic [IW-1:0] idx;
        logic [LW-1:0] ptr;
        logic [LW-1:0] step_ptr;
        logic          cap_dir;

        vperm_serial_step #(.N(N), .W(W), .LW(LW), .IW(IW)) u_step (
            .dir      (cap_dir),
            .bit_set  (cap_mask[idx]),
            .idx      (idx),
            .ptr      (ptr),
            .src      (cap_src),
            .work     (work),
            .work_nxt (step_work),
            .ptr_nxt  (step_ptr)
        );

        assign scan_last = (idx == IW'(N - 1));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < N; k++) begin
                    cap_src[k] <= '0;
                    work[k]    <= '0;
                    res_q[k]   <= '0;
                end
                cap_dir  <= 1'b0;
                cap_mask <= '0;
                idx      <= '0;
                ptr      <= '0;
                len_q    <= '0;
            end else if (accept) begin
                cap_dir  <= dir;
                cap_mask <= mask;
                cap_src  <= src_arr;
                work     <= dst_arr;
                idx      <= '0;
                ptr      <= '0;
            end else if (state == ST_SCAN) begin
                work <= step_work;
                ptr  <= step_ptr;
                idx  <= idx + 1'b1;
                if (scan_last) begin
                    res_q <= step_work;
                    len_q <= step_ptr;
                end
            end
        end
    end else begin : g_parallel
        logic [W-1:0]  par_res [N];
        logic [LW-1:0] par_len;

        vperm_parallel #(.N(N), .W(W), .LW(LW), .IW(IW)) u_par (
            .dir  (dir),
            .mask (mask),
            .src  (src_arr),
            .dst  (dst_arr),
            .res  (par_res),
            .len  (par_len)
        );

        assign scan_last = 1'b1;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < N; k++) begin
                    res_q[k] <= '0;
                end
                len_q    <= '0;
                cap_mask <= '0;
            end else if (accept) begin
                res_q    <= par_res;
                len_q    <= par_len;
                cap_mask <= mask;
            end
        end
    end

endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk #(
    parameter int N      = 8,
    parameter int W      = 8,
    parameter int SERIAL = 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        busy,
    input logic                        done,
    input logic [N*W-1:0]              result_flat,
    input logic [$clog2(N+1)-1:0]      packed_len,
    input logic [N-1:0]                cap_mask
);

    localparam int LW  = $clog2(N + 1);
    localparam int LAT = (SERIAL != 0) ? N + 1 : 1;

    // Cycles since the accepting edge, counted in the checker.
    int unsigned lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= 0;
        end else if (start && !busy) begin
            lat_cnt <= 1;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LAT));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result_flat) && $stable(packed_len)));

    assert_len_popcount_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (packed_len == LW'($countones(cap_mask))));

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_scan_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind vperm_unit vperm_unit_chk #(
    .N      (NUM_ELEM),
    .W      (ELEM_W),
    .SERIAL (SERIAL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .result_flat (result_flat),
    .packed_len  (packed_len),
    .cap_mask    (cap_mask)
);

// File: tb/vperm_unit_tb.sv
module vperm_unit_tb;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int VW = N * W;
    localparam int LW = $clog2(N + 1);
    localparam int NV = 11;

    // Element i of the source is 8'hAi, of the old destination 8'hBi (R6).
    localparam logic [VW-1:0] SRC = 64'hA7A6A5A4A3A2A1A0;
    localparam logic [VW-1:0] DST = 64'hB7B6B5B4B3B2B1B0;

    typedef struct packed {
        logic          dir;
        logic [N-1:0]  mask;
        logic [VW-1:0] res;
        logic [LW-1:0] len;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'hB2, 64'hB7B6B5B4A7A5A4A1, 4'd4},
        '{1'b1, 8'hB2, 64'hA3B6A2A1B3B2A0B0, 4'd4},
        '{1'b0, 8'hFF, 64'hA7A6A5A4A3A2A1A0, 4'd8},
        '{1'b1, 8'hFF, 64'hA7A6A5A4A3A2A1A0, 4'd8},
        '{1'b0, 8'h00, 64'hB7B6B5B4B3B2B1B0, 4'd0},
        '{1'b1, 8'h00, 64'hB7B6B5B4B3B2B1B0, 4'd0},
        '{1'b0, 8'h80, 64'hB7B6B5B4B3B2B1A7, 4'd1},
        '{1'b1, 8'h01, 64'hB7B6B5B4B3B2B1A0, 4'd1},
        '{1'b1, 8'h80, 64'hA0B6B5B4B3B2B1B0, 4'd1},
        '{1'b0, 8'h55, 64'hB7B6B5B4A6A4A2A0, 4'd4},
        '{1'b1, 8'hAA, 64'hA3B6A2B4A1B2A0B0, 4'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          d_start = 1'b0;
    logic          d_dir = 1'b0;
    logic [N-1:0]  d_mask = '0;
    logic [VW-1:0] d_src = '0;
    logic [VW-1:0] d_dst = '0;

    logic          s_busy, s_done, f_busy, f_done;
    logic [VW-1:0] s_res, f_res;
    logic [LW-1:0] s_len, f_len;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    vperm_unit #(.ELEM_W(W), .NUM_ELEM(N), .SERIAL(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(d_start), .dir(d_dir), .mask(d_mask),
        .src_flat(d_src), .dst_flat(d_dst), .busy(s_busy), .done(s_done),
        .result_flat(s_res), .packed_len(s_len)
    );

    vperm_unit #(.ELEM_W(W), .NUM_ELEM(N), .SERIAL(0)) u_dut_fast (
        .clk(clk), .rst_n(rst_n), .start(d_start), .dir(d_dir), .mask(d_mask),
        .src_flat(d_src), .dst_flat(d_dst), .busy(f_busy), .done(f_done),
        .result_flat(f_res), .packed_len(f_len)
    );

    task automatic check(input string req, input string what,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            tests++;
            $display("FAIL R7 watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Launch one request and wait for both variants to report.
    task automatic run_vec(input logic dr, input logic [N-1:0] m,
                           input logic [VW-1:0] s, input logic [VW-1:0] t,
                           output logic [VW-1:0] rs, output logic [LW-1:0] ls,
                           output int lats,
                           output logic [VW-1:0] rf, output logic [LW-1:0] lf,
                           output int latf);
        logic gs, gf;
        gs = 1'b0; gf = 1'b0;
        rs = '0; ls = '0; lats = 0; rf = '0; lf = '0; latf = 0;
        @(negedge clk);
        d_dir = dr; d_mask = m; d_src = s; d_dst = t; d_start = 1'b1;
        @(negedge clk);
        d_start = 1'b0;
        for (int c = 1; c <= 40; c++) begin
            if (!gf && f_done) begin gf = 1'b1; rf = f_res; lf = f_len; latf = c; end
            if (!gs && s_done) begin gs = 1'b1; rs = s_res; ls = s_len; lats = c; end
            if (gs && gf) break;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [VW-1:0] rs, rf, held;
        logic [LW-1:0] ls, lf;
        int lats, latf, extra;

        // Reset state (R9)
        @(negedge clk);
        @(negedge clk);
        check("R9", "serial busy/done", {62'd0, s_busy, s_done}, '0);
        check("R9", "fast busy/done", {62'd0, f_busy, f_done}, '0);
        check("R9", "serial result", s_res, '0);
        check("R9", "serial len", VW'(s_len), '0);
        check("R9", "fast result", f_res, '0);
        rst_n = 1'b1;

        // Vector table: R1/R2 pack, R4/R5 unpack, R3 length, R7 timing, R10 match
        for (int v = 0; v < NV; v++) begin
            run_vec(TBL[v].dir, TBL[v].mask, SRC, DST, rs, ls, lats, rf, lf, latf);
            check(TBL[v].dir ? "R4/R5/R6" : "R1/R2/R6", $sformatf("vec %0d result", v),
                  rs, TBL[v].res);
            check("R3", $sformatf("vec %0d len", v), VW'(ls), VW'(TBL[v].len));
            check("R7", $sformatf("vec %0d serial latency", v), VW'(lats), VW'(N + 1));
            check("R7", $sformatf("vec %0d fast latency", v), VW'(latf), VW'(1));
            check("R10", $sformatf("vec %0d fast result", v), rf, TBL[v].res);
            check("R10", $sformatf("vec %0d fast len", v), VW'(lf), VW'(TBL[v].len));
            @(negedge clk);
            check("R7", $sformatf("vec %0d done pulse ends", v), VW'(s_done), '0);
        end

        // R8: start pulses during the scan and in the done cycle are ignored
        @(negedge clk);
        d_dir = 1'b0; d_mask = 8'hB2; d_src = SRC; d_dst = DST; d_start = 1'b1;
        @(negedge clk);
        d_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        d_dir = 1'b1; d_mask = 8'hFF; d_src = 64'h1122334455667788; d_start = 1'b1;
        @(negedge clk);
        d_start = 1'b0;
        for (int c = 0; c < 40 && !s_done; c++) @(negedge clk);
        check("R8", "result after start during scan", s_res, TBL[0].res);
        check("R8", "len after start during scan", VW'(s_len), VW'(4));
        d_start = 1'b1;
        @(negedge clk);
        d_start = 1'b0;
        check("R8", "busy after start in done cycle", VW'(s_busy), '0);
        extra = 0;
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            if (s_done) extra++;
        end
        check("R8", "no extra done", VW'(extra), '0);
        check("R8", "result untouched", s_res, TBL[0].res);

        // R7: result holds while idle with changing inputs
        held = s_res;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            d_mask = d_mask ^ 8'h5A;
            d_src  = {d_src[VW-9:0], d_src[VW-1:VW-8]};
            d_dir  = ~d_dir;
        end
        check("R7", "result held while idle", s_res, held);
        check("R7", "len held while idle", VW'(s_len), VW'(4));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule